// File: doc/BRIEF.md
# Staged Control Pipeline for a Five-Stage Core

This block turns one instruction's opcode and function bits into control bundles during decode. It does that decode exactly once. The bundles then ride through three pipeline registers: decode-to-execute, execute-to-memory and memory-to-writeback. Each stage reads its own controls from the register in front of it:

- the execute stage gets an ALU operation;
- the memory stage gets read and write strobes, plus the access size and extension type;
- the writeback stage gets a register-write enable and a destination register number.

Each register keeps only the fields that stages further down still need. The memory strobes stop at the execute-to-memory register. The write enable and destination travel all the way to writeback.

The function bits are not turned into an ALU operation during decode. They are latched raw, together with a coarse ALU class, and a small local decoder in the execute stage expands them. A hazard unit outside this block can stall the decode-to-execute register, which also drops a bubble into the execute-to-memory register. It can also flush any single register, which turns that register into a bubble with no side effects. The datapath (ALU, register file, memories) sits outside this block.

Top module: `ctl_pipe`

## Requirements
- R1: While `rst` is high at a rising clock edge, all three pipeline registers are cleared. After that edge, `ex_alu_op` is 0, and `mem_rd`, `mem_wr`, `mem_size`, `mem_unsigned`, `wb_we` and `wb_dst` are all 0.
- R2: Opcode encodings are 0 register-register, 1 add-immediate, 2 load, 3 store, 4 branch-compare and 5 load-upper. Any other value decodes to a bundle with every control at zero. A valid instruction presented in cycle n drives `ex_alu_op` after edge n+1, the memory outputs after edge n+2 and the writeback outputs after edge n+3.
- R3: `ex_alu_op` codes are ADD=0, SUB=1, AND=2, OR=3, XOR=4, SLT=5, SLL=6, SRL=7 and PASSB=8. A register-register instruction yields the code equal to its 3-bit `id_funct`. Add-immediate, load and store yield ADD, branch-compare yields SUB and load-upper yields PASSB.
- R4: A load raises `mem_rd` and a store raises `mem_wr` in the memory stage. No other opcode raises either strobe, and the two are never high together.
- R5: For a load or store, `id_funct[1:0]` sets `mem_size`: 0 is byte, 1 is half-word, and 2 or 3 both give word (2). `id_funct[2]` sets `mem_unsigned` for loads only. A store gives `mem_unsigned`=0, and every non-memory opcode gives `mem_size`=0 and `mem_unsigned`=0.
- R6: In writeback, `wb_we` is 1 for register-register (with `wb_dst`=`id_rd`) and for add-immediate, load and load-upper (with `wb_dst`=`id_rt`). For every other instruction, `wb_we` is 0 and `wb_dst` is 0.
- R7: When `id_valid` is 0, the decoder produces a bubble whatever the opcode is. A bubble means ALU op 0, both strobes 0 and `wb_we`=0.
- R8: With `idex_stall` high at an edge, the decode-to-execute register keeps its contents and the decode inputs are ignored. The execute-to-memory register takes a bubble, and the held instruction moves on once the stall drops.
- R9: `idex_flush`, `exmem_flush` and `memwb_flush` each load a bubble into their own register at the edge where they are high. `idex_flush` takes priority over `idex_stall`.
- R10: Instructions issued on consecutive cycles each reach their own stage outputs unaffected by their neighbours.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| id_valid | input | 1 | Decode slot holds a real instruction |
| id_opcode | input | 4 | Instruction opcode |
| id_funct | input | 3 | Function bits (ALU select, or size/extension for memory ops) |
| id_rt | input | 5 | Second register field, destination for immediate forms |
| id_rd | input | 5 | Third register field, destination for register-register form |
| idex_stall | input | 1 | Hold decode-to-execute register, bubble into next |
| idex_flush | input | 1 | Bubble into decode-to-execute register |
| exmem_flush | input | 1 | Bubble into execute-to-memory register |
| memwb_flush | input | 1 | Bubble into memory-to-writeback register |
| ex_alu_op | output | 4 | ALU operation for the execute stage |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_size | output | 2 | Access size: 0 byte, 1 half, 2 word |
| mem_unsigned | output | 1 | Zero-extend loaded data |
| wb_we | output | 1 | Register-file write enable |
| wb_dst | output | 5 | Register-file destination |

## Verification
If a control field is corrupted in one register, it shows up at the ports exactly as many edges later as there are registers between decode and the stage that reads it. A bad ALU selection appears one edge after issue, a wrong strobe two edges after and a wrong write enable or destination three edges after. A stall or flush that fails to clear a write field is the most damaging fault, because it turns a bubble into a spurious memory access or register write. For that reason, every stall and flush scenario checks the strobes and the write enable at the exact edge where the bubble reaches them. Back-to-back issue checks that one instruction's fields never leak into its neighbour's stage outputs.

// File: rtl/ctl_pkg.sv
package ctl_pkg;

    localparam int OPC_W    = 4;
    localparam int FN_W     = 3;
    localparam int RA_W     = 5;
    localparam int ALU_OP_W = 4;
    localparam int SIZE_W   = 2;

    localparam logic [OPC_W-1:0] OPC_REG   = OPC_W'(0);
    localparam logic [OPC_W-1:0] OPC_ADDI  = OPC_W'(1);
    localparam logic [OPC_W-1:0] OPC_LOAD  = OPC_W'(2);
    localparam logic [OPC_W-1:0] OPC_STORE = OPC_W'(3);
    localparam logic [OPC_W-1:0] OPC_BEQ   = OPC_W'(4);
    localparam logic [OPC_W-1:0] OPC_LUI   = OPC_W'(5);

    // coarse ALU class chosen in decode; refined in execute
    typedef enum logic [1:0] {
        CLS_ADD   = 2'd0,
        CLS_SUB   = 2'd1,
        CLS_FUNCT = 2'd2,
        CLS_PASSB = 2'd3
    } alu_cls_e;

    typedef enum logic [ALU_OP_W-1:0] {
        AF_ADD   = 4'd0,
        AF_SUB   = 4'd1,
        AF_AND   = 4'd2,
        AF_OR    = 4'd3,
        AF_XOR   = 4'd4,
        AF_SLT   = 4'd5,
        AF_SLL   = 4'd6,
        AF_SRL   = 4'd7,
        AF_PASSB = 4'd8
    } alu_fn_e;

    typedef enum logic [SIZE_W-1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } mem_size_e;

    typedef struct packed {
        alu_cls_e          cls;
        logic [FN_W-1:0]   fn;
    } ex_ctl_t;

    typedef struct packed {
        logic      rd;
        logic      wr;
        mem_size_e size;
        logic      uns;
    } mem_ctl_t;

    typedef struct packed {
        logic            we;
        logic [RA_W-1:0] dst;
    } wb_ctl_t;

    typedef struct packed {
        ex_ctl_t  ex;
        mem_ctl_t mem;
        wb_ctl_t  wb;
    } idex_t;

    typedef struct packed {
        mem_ctl_t mem;
        wb_ctl_t  wb;
    } exmem_t;

    typedef wb_ctl_t memwb_t;

    function automatic mem_size_e size_from_bits(input logic [1:0] b);
        case (b)
            2'd0:    return SZ_BYTE;
            2'd1:    return SZ_HALF;
            default: return SZ_WORD;
        endcase
    endfunction

    function automatic alu_fn_e fn_from_funct(input logic [FN_W-1:0] f);
        case (f)
            3'd0:    return AF_ADD;
            3'd1:    return AF_SUB;
            3'd2:    return AF_AND;
            3'd3:    return AF_OR;
            3'd4:    return AF_XOR;
            3'd5:    return AF_SLT;
            3'd6:    return AF_SLL;
            default: return AF_SRL;
        endcase
    endfunction

endpackage

// File: rtl/ctl_decode.sv
module ctl_decode
    import ctl_pkg::*;
(
    input  logic             valid,
    input  logic [OPC_W-1:0] opcode,
    input  logic [FN_W-1:0]  funct,
    input  logic [RA_W-1:0]  rt,
    input  logic [RA_W-1:0]  rd,
    output idex_t            bundle
);

    always_comb begin
        bundle = '0;
        if (valid) begin
            case (opcode)
                OPC_REG: begin
                    bundle.ex.cls = CLS_FUNCT;
                    bundle.ex.fn  = funct;
                    bundle.wb.we  = 1'b1;
                    bundle.wb.dst = rd;
                end
                OPC_ADDI: begin
                    bundle.ex.cls = CLS_ADD;
                    bundle.wb.we  = 1'b1;
                    bundle.wb.dst = rt;
                end
                OPC_LOAD: begin
                    bundle.ex.cls   = CLS_ADD;
                    bundle.mem.rd   = 1'b1;
                    bundle.mem.size = size_from_bits(funct[1:0]);
                    bundle.mem.uns  = funct[2];
                    bundle.wb.we    = 1'b1;
                    bundle.wb.dst   = rt;
                end
                OPC_STORE: begin
                    bundle.ex.cls   = CLS_ADD;
                    bundle.mem.wr   = 1'b1;
                    bundle.mem.size = size_from_bits(funct[1:0]);
                end
                OPC_BEQ: begin
                    bundle.ex.cls = CLS_SUB;
                end
                OPC_LUI: begin
                    bundle.ex.cls = CLS_PASSB;
                    bundle.wb.we  = 1'b1;
                    bundle.wb.dst = rt;
                end
                default: bundle = '0;
            endcase
        end
    end

endmodule

// File: rtl/alu_ctl.sv
module alu_ctl
    import ctl_pkg::*;
(
    input  ex_ctl_t ctl,
    output alu_fn_e op
);

    always_comb begin
        case (ctl.cls)
            CLS_SUB:   op = AF_SUB;
            CLS_FUNCT: op = fn_from_funct(ctl.fn);
            CLS_PASSB: op = AF_PASSB;
            default:   op = AF_ADD;
        endcase
    end

endmodule

// File: rtl/ctl_stage_reg.sv
module ctl_stage_reg #(
    parameter type T = logic
) (
    input  logic clk,
    input  logic rst,
    input  logic hold,
    input  logic bubble,
    input  T     d,
    output T     q
);

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (bubble)
            q <= '0;
        else if (!hold)
            q <= d;
    end

endmodule

// File: rtl/ctl_pipe.sv
module ctl_pipe
    import ctl_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                id_valid,
    input  logic [OPC_W-1:0]    id_opcode,
    input  logic [FN_W-1:0]     id_funct,
    input  logic [RA_W-1:0]     id_rt,
    input  logic [RA_W-1:0]     id_rd,
    input  logic                idex_stall,
    input  logic                idex_flush,
    input  logic                exmem_flush,
    input  logic                memwb_flush,
    output logic [ALU_OP_W-1:0] ex_alu_op,
    output logic                mem_rd,
    output logic                mem_wr,
    output logic [SIZE_W-1:0]   mem_size,
    output logic                mem_unsigned,
    output logic                wb_we,
    output logic [RA_W-1:0]     wb_dst
);

    idex_t   dec_bundle;
    idex_t   idex_q;
    exmem_t  exmem_d;
    exmem_t  exmem_q;
    memwb_t  memwb_q;
    alu_fn_e alu_sel;

    // decode: the only place the opcode is examined
    ctl_decode u_dec (
        .valid  (id_valid),
        .opcode (id_opcode),
        .funct  (id_funct),
        .rt     (id_rt),
        .rd     (id_rd),
        .bundle (dec_bundle)
    );

    ctl_stage_reg #(.T(idex_t)) u_idex (
        .clk    (clk),
        .rst    (rst),
        .hold   (idex_stall),
        .bubble (idex_flush),
        .d      (dec_bundle),
        .q      (idex_q)
    );

    // execute: local expansion of the latched function bits
    alu_ctl u_alu_ctl (
        .ctl (idex_q.ex),
        .op  (alu_sel)
    );

    // execute-side fields are dropped here
    assign exmem_d = '{mem: idex_q.mem, wb: idex_q.wb};

    ctl_stage_reg #(.T(exmem_t)) u_exmem (
        .clk    (clk),
        .rst    (rst),
        .hold   (1'b0),
        .bubble (exmem_flush | idex_stall),
        .d      (exmem_d),
        .q      (exmem_q)
    );

    // memory-side fields are dropped here
    ctl_stage_reg #(.T(memwb_t)) u_memwb (
        .clk    (clk),
        .rst    (rst),
        .hold   (1'b0),
        .bubble (memwb_flush),
        .d      (exmem_q.wb),
        .q      (memwb_q)
    );

    assign ex_alu_op    = alu_sel;
    assign mem_rd       = exmem_q.mem.rd;
    assign mem_wr       = exmem_q.mem.wr;
    assign mem_size     = exmem_q.mem.size;
    assign mem_unsigned = exmem_q.mem.uns;
    assign wb_we        = memwb_q.we;
    assign wb_dst       = memwb_q.dst;

endmodule

// File: rtl/ctl_pipe_chk.sv
module ctl_pipe_chk
    import ctl_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                id_valid,
    input logic                idex_stall,
    input logic                idex_flush,
    input logic                exmem_flush,
    input logic                memwb_flush,
    input logic [ALU_OP_W-1:0] ex_alu_op,
    input logic                mem_rd,
    input logic                mem_wr,
    input logic                mem_unsigned,
    input logic                wb_we,
    input logic [RA_W-1:0]     wb_dst
);

    p_strobe_excl_r4: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mem_rd, mem_wr}));

    p_uns_only_load_r5: assert property (@(posedge clk) disable iff (rst)
        mem_unsigned |-> mem_rd);

    p_stall_bubble_r8: assert property (@(posedge clk) disable iff (rst)
        idex_stall |=> (!mem_rd && !mem_wr));

    p_stall_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (idex_stall && !idex_flush) |=> $stable(ex_alu_op));

    p_flush_idex_r9: assert property (@(posedge clk) disable iff (rst)
        idex_flush |=> (ex_alu_op == ALU_OP_W'(AF_ADD)));

    p_flush_exmem_r9: assert property (@(posedge clk) disable iff (rst)
        exmem_flush |=> (!mem_rd && !mem_wr));

    p_flush_memwb_r9: assert property (@(posedge clk) disable iff (rst)
        memwb_flush |=> (!wb_we && wb_dst == '0));

    p_invalid_bubble_r7: assert property (@(posedge clk) disable iff (rst)
        (!id_valid && !idex_stall) |-> ##2 (!mem_rd && !mem_wr));

endmodule

bind ctl_pipe ctl_pipe_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .id_valid     (id_valid),
    .idex_stall   (idex_stall),
    .idex_flush   (idex_flush),
    .exmem_flush  (exmem_flush),
    .memwb_flush  (memwb_flush),
    .ex_alu_op    (ex_alu_op),
    .mem_rd       (mem_rd),
    .mem_wr       (mem_wr),
    .mem_unsigned (mem_unsigned),
    .wb_we        (wb_we),
    .wb_dst       (wb_dst)
);

// File: tb/sim_ctl_pipe.sv
`timescale 1ns/1ps
module sim_ctl_pipe;

    logic       clk = 1'b0;
    logic       rst;
    logic       id_valid;
    logic [3:0] id_opcode;
    logic [2:0] id_funct;
    logic [4:0] id_rt, id_rd;
    logic       idex_stall, idex_flush, exmem_flush, memwb_flush;
    logic [3:0] ex_alu_op;
    logic       mem_rd, mem_wr, mem_unsigned, wb_we;
    logic [1:0] mem_size;
    logic [4:0] wb_dst;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    ctl_pipe u0 (
        .clk(clk), .rst(rst), .id_valid(id_valid), .id_opcode(id_opcode),
        .id_funct(id_funct), .id_rt(id_rt), .id_rd(id_rd),
        .idex_stall(idex_stall), .idex_flush(idex_flush),
        .exmem_flush(exmem_flush), .memwb_flush(memwb_flush),
        .ex_alu_op(ex_alu_op), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_size(mem_size), .mem_unsigned(mem_unsigned),
        .wb_we(wb_we), .wb_dst(wb_dst)
    );

    typedef struct {
        int alu; int rd; int wr; int size; int uns; int we; int dst;
    } exp_t;

    // expected controls from the requirement tables (R2, R3, R5, R6)
    function automatic exp_t expect_of(int op, int fn, int rt, int rd);
        exp_t e = '{0, 0, 0, 0, 0, 0, 0};
        int sz = ((fn & 3) == 3) ? 2 : (fn & 3);
        case (op)
            0: begin e.alu = fn; e.we = 1; e.dst = rd; end
            1: begin e.we = 1; e.dst = rt; end
            2: begin e.rd = 1; e.size = sz; e.uns = (fn >> 2) & 1; e.we = 1; e.dst = rt; end
            3: begin e.wr = 1; e.size = sz; end
            4: e.alu = 1;
            5: begin e.alu = 8; e.we = 1; e.dst = rt; end
            default: ;
        endcase
        return e;
    endfunction

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic drive(bit v, int op, int fn, int rt, int rd,
                         bit st = 0, bit fi = 0, bit fe = 0, bit fm = 0);
        id_valid    = v;
        id_opcode   = 4'(op);
        id_funct    = 3'(fn);
        id_rt       = 5'(rt);
        id_rd       = 5'(rd);
        idex_stall  = st;
        idex_flush  = fi;
        exmem_flush = fe;
        memwb_flush = fm;
    endtask

    task automatic idle();
        drive(0, 0, 0, 0, 0);
    endtask

    task automatic chk_ex(string tag, exp_t e);
        chk({tag, " alu"}, int'(ex_alu_op), e.alu);
    endtask

    task automatic chk_mem(string tag, exp_t e);
        chk({tag, " mem_rd"}, int'(mem_rd), e.rd);
        chk({tag, " mem_wr"}, int'(mem_wr), e.wr);
        chk({tag, " size"},   int'(mem_size), e.size);
        chk({tag, " uns"},    int'(mem_unsigned), e.uns);
    endtask

    task automatic chk_wb(string tag, exp_t e);
        chk({tag, " wb_we"},  int'(wb_we), e.we);
        chk({tag, " wb_dst"}, int'(wb_dst), e.dst);
    endtask

    task automatic chk_all_zero(string tag);
        exp_t z = '{0, 0, 0, 0, 0, 0, 0};
        chk_ex(tag, z); chk_mem(tag, z); chk_wb(tag, z);
    endtask

    // R1: state after reset
    task automatic t_reset();
        rst = 1'b1;
        idle();
        repeat (3) tick();
        chk_all_zero("R1 reset");
        rst = 1'b0;
    endtask

    // R2..R6: one instruction walking through all stages
    task automatic t_single(string tag, int op, int fn, int rt, int rd);
        exp_t e = expect_of(op, fn, rt, rd);
        drive(1, op, fn, rt, rd);
        tick(); chk_ex(tag, e);
        idle();
        tick(); chk_mem(tag, e);
        tick(); chk_wb(tag, e);
        tick();
    endtask

    // R7: invalid slot is a bubble
    task automatic t_invalid();
        exp_t z = '{0, 0, 0, 0, 0, 0, 0};
        drive(0, 2, 5, 9, 0);
        tick(); chk_ex("R7 invalid", z);
        idle();
        tick(); chk_mem("R7 invalid", z);
        tick(); chk_wb("R7 invalid", z);
    endtask

    // R10: back-to-back issue
    task automatic t_b2b();
        exp_t ld = expect_of(2, 1, 7, 0);
        exp_t st = expect_of(3, 2, 9, 0);
        exp_t rr = expect_of(0, 5, 0, 12);
        drive(1, 2, 1, 7, 0); tick();
        drive(1, 3, 2, 9, 0); tick();
        drive(1, 0, 5, 0, 12); tick();
        chk_ex("R10 b2b slt", rr);
        chk_mem("R10 b2b store", st);
        chk_wb("R10 b2b load", ld);
        idle(); tick();
        chk_mem("R10 b2b regop", rr);
        chk_wb("R10 b2b store", st);
        tick();
        chk_wb("R10 b2b regop", rr);
        tick();
    endtask

    // R8: stall holds execute, bubbles memory stage
    task automatic t_stall();
        exp_t st = expect_of(3, 1, 3, 0);
        exp_t xr = expect_of(0, 4, 0, 6);
        exp_t z  = '{0, 0, 0, 0, 0, 0, 0};
        drive(1, 3, 1, 3, 0); tick();
        chk_ex("R8 pre-stall", st);
        drive(1, 0, 4, 0, 6, 1); tick();
        chk_ex("R8 held during stall", st);
        chk_mem("R8 bubble during stall", z);
        drive(1, 0, 4, 0, 6); tick();
        chk_ex("R8 next after stall", xr);
        chk_mem("R8 held store reaches mem", st);
        idle(); tick();
        chk_wb("R8 store no write", st);
        tick();
        chk_wb("R8 regop write", xr);
        tick();
    endtask

    // R9: flush of each register, flush over stall
    task automatic t_flush();
        exp_t z = '{0, 0, 0, 0, 0, 0, 0};
        // flush wins over stall at decode-to-execute
        drive(1, 5, 0, 2, 0); tick();
        chk_ex("R9 lui in ex", expect_of(5, 0, 2, 0));
        drive(1, 2, 0, 4, 0, 1, 1); tick();
        chk_ex("R9 idex flush over stall", z);
        idle(); tick();
        chk_mem("R9 idex flush mem", z);
        tick();
        chk_wb("R9 idex flush wb", z);
        // flush at execute-to-memory
        drive(1, 2, 0, 5, 0); tick();
        drive(0, 0, 0, 0, 0, 0, 0, 1); tick();
        chk_mem("R9 exmem flush", z);
        idle(); tick();
        chk_wb("R9 exmem flush wb", z);
        // flush at memory-to-writeback
        drive(1, 1, 0, 11, 0); tick();
        idle(); tick();
        chk_wb("R9 memwb pre", z);
        drive(0, 0, 0, 0, 0, 0, 0, 0, 1); tick();
        chk_wb("R9 memwb flush", z);
        idle(); tick();
    endtask

    // R1: reset in the middle of traffic
    task automatic t_reset_mid();
        drive(1, 0, 7, 0, 1); tick();
        drive(1, 2, 6, 3, 0); tick();
        rst = 1'b1; idle(); tick();
        chk_all_zero("R1 reset mid-run");
        rst = 1'b0; tick();
    endtask

    initial begin
        t_reset();
        t_single("R2 R3 R6 regop add",   0, 0, 4, 21);
        t_single("R3 regop sub",         0, 1, 0, 2);
        t_single("R3 regop and",         0, 2, 0, 3);
        t_single("R3 regop or",          0, 3, 0, 4);
        t_single("R3 regop xor",         0, 4, 0, 5);
        t_single("R3 regop slt",         0, 5, 0, 6);
        t_single("R3 regop sll",         0, 6, 0, 7);
        t_single("R3 regop srl",         0, 7, 1, 31);
        t_single("R6 addi",              1, 3, 17, 30);
        t_single("R4 R5 load byte sx",   2, 0, 8, 0);
        t_single("R5 load half zx",      2, 5, 9, 0);
        t_single("R5 load size3 word",   2, 3, 10, 0);
        t_single("R5 load word zx",      2, 6, 13, 0);
        t_single("R4 R5 store half",     3, 5, 14, 22);
        t_single("R5 store size3",       3, 7, 15, 0);
        t_single("R2 beq",               4, 2, 16, 23);
        t_single("R3 lui passb",         5, 0, 18, 0);
        t_single("R2 undefined op",      9, 6, 19, 24);
        t_single("R2 undefined op15",    15, 1, 20, 25);
        t_invalid();
        t_b2b();
        t_stall();
        t_flush();
        t_reset_mid();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule